// File: doc/BRIEF.md
# Serial Port Command and Status Sequencer

This block is the host-facing command front end of one serial port channel. The host picks an operation by writing an opcode byte to the command register. It then supplies that operation's operands one byte at a time through a single argument register. The sequencer tracks the active opcode and how many operands it has taken so far. Each operand is committed straight into the setup register it belongs to. The setup registers drive the rest of the port as plain parameter outputs.

Query opcodes take a snapshot of a status input at the moment the opcode is written. The result is held in a two-byte result pair that the host reads back at the same two offsets. A read of the low result byte closes the query. Writing a new opcode before the current one has all its operands abandons the old one at once. The UART, the FIFOs and the DMA engine are outside this block. They appear only as count inputs and as flush pulses.

Top module: `portcmd_seq`

## Requirements
- R1: A write with `addr`=4 is an opcode write and a write with `addr`=5 is an operand write; writes at any other offset have no effect. While `rd_en` is high, `rdata` shows the high result byte at offset 4, the low result byte at offset 5 and 00h at any other offset; `rdata` is 00h while `rd_en` is low.
- R2: Opcode 0Ah takes 4 operands in the order flow-off high, flow-off low, flow-on high, flow-on low. Opcode 0Bh takes 4 operands in the order Rx trigger high, Rx trigger low, Tx trigger high, Tx trigger low. A high byte supplies level bits 9:8 from its bits 1:0, and a low byte supplies bits 7:0. Each operand updates its output on the clock edge at which it is written.
- R3: Operand writes beyond an opcode's operand count, and operand writes after an opcode that takes none (including undefined opcodes), leave every setup output unchanged.
- R4: An opcode write always restarts operand counting at the first operand. Setup fields the abandoned opcode never reached keep their earlier values.
- R5: Opcode 09h takes 5 operands: XON character, XOFF character, escape character, XOR character, compare mask. Opcode 07h takes 2 operands, which form `err_mask` bits 7:0 and then bits 15:8.
- R6: Opcodes 05h (`dma_tmo`), 0Ch (`rxchr_tmo`) and 0Dh (`floff_tmo`) each take one operand, which is stored unchanged.
- R7: Opcode 10h takes one mode operand. When its bit 0 is 1, bits 3:1 are stored as 0. When its bit 0 is 0, bits 5:4 are stored as 0. All other bits are stored as written.
- R8: Opcodes 14h and 15h capture `rx_count` and `tx_space` respectively, zero-extended to 16 bits, into the result pair when the opcode is written. The high byte is at offset 4 and the low byte at offset 5.
- R9: Opcode 22h captures `err_count` into the result pair (high byte, low byte). Every other opcode loads 00h into both result bytes. The result pair holds until a read at offset 5, after which both bytes are 00h from the next cycle; an opcode write in the same cycle as that read takes precedence.
- R10: Opcode 1Eh loads 00h into the high result byte and the stored mode byte into the low result byte.
- R11: Opcode 00h zeroes every setup output and raises `flush_rx` and `flush_tx` for one cycle starting after the write edge. Opcode 1Bh pulses only `flush_rx` and opcode 1Ch pulses only `flush_tx`.
- R12: While `rst` is high, all setup outputs, both result bytes and both flush pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset within the port window |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| rx_count | input | 10 | Bytes waiting in the receive FIFO |
| tx_space | input | 10 | Free bytes in the transmit FIFO |
| err_count | input | 16 | Receive error counter |
| flow_off_lvl | output | 10 | Receive level that stops the remote sender |
| flow_on_lvl | output | 10 | Receive level that restarts the remote sender |
| rx_trig_lvl | output | 10 | Receive service trigger level |
| tx_trig_lvl | output | 10 | Transmit service trigger level |
| dma_tmo | output | 8 | DMA gap timeout |
| rxchr_tmo | output | 8 | Receive character timeout |
| floff_tmo | output | 8 | Flowed-off timeout |
| err_mask | output | 16 | Error condition enable mask |
| xon_chr | output | 8 | Resume character |
| xoff_chr | output | 8 | Pause character |
| esc_chr | output | 8 | Escape character |
| xor_chr | output | 8 | Escape XOR pattern |
| cmp_mask | output | 8 | Bit mask for control character compares |
| mode_byte | output | 8 | Stored operating mode |
| flush_rx | output | 1 | One-cycle receive FIFO flush request |
| flush_tx | output | 1 | One-cycle transmit FIFO flush request |

## Verification
The assertions check the following on every cycle:
- each opcode write restarts operand counting;
- surplus operands leave the setup outputs untouched;
- flush pulses follow only opcode writes;
- the result pair holds or clears as STAT2 reads dictate;
- the stored mode byte never carries the bits its mode ignores.

Only the bench scenarios show the rest:
- that each operand lands in the right field in the right order;
- that an abort keeps unreached fields;
- that query snapshots carry the right count values with the right byte split.

// File: rtl/portcmd_pkg.sv
package portcmd_pkg;

    localparam int BYTE_W  = 8;
    localparam int RES_W   = 16;
    localparam int IDX_W   = 3;

    localparam logic [2:0] OFF_OPC = 3'd4;
    localparam logic [2:0] OFF_ARG = 3'd5;

    localparam logic [7:0] OP_CLEAR    = 8'h00;
    localparam logic [7:0] OP_DMA_TMO  = 8'h05;
    localparam logic [7:0] OP_ERR_MASK = 8'h07;
    localparam logic [7:0] OP_CHARS    = 8'h09;
    localparam logic [7:0] OP_FLOW_LVL = 8'h0A;
    localparam logic [7:0] OP_TRIG_LVL = 8'h0B;
    localparam logic [7:0] OP_RX_TMO   = 8'h0C;
    localparam logic [7:0] OP_FL_TMO   = 8'h0D;
    localparam logic [7:0] OP_MODE     = 8'h10;
    localparam logic [7:0] OP_RX_AVAIL = 8'h14;
    localparam logic [7:0] OP_TX_AVAIL = 8'h15;
    localparam logic [7:0] OP_FLUSH_RX = 8'h1B;
    localparam logic [7:0] OP_FLUSH_TX = 8'h1C;
    localparam logic [7:0] OP_GET_MODE = 8'h1E;
    localparam logic [7:0] OP_ERR_CNT  = 8'h22;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } res_t;

    function automatic logic [IDX_W-1:0] operand_count(input logic [7:0] op);
        case (op)
            OP_DMA_TMO, OP_RX_TMO, OP_FL_TMO, OP_MODE: operand_count = 3'd1;
            OP_ERR_MASK:                               operand_count = 3'd2;
            OP_FLOW_LVL, OP_TRIG_LVL:                  operand_count = 3'd4;
            OP_CHARS:                                  operand_count = 3'd5;
            default:                                   operand_count = 3'd0;
        endcase
    endfunction

    function automatic logic [7:0] mask_mode(input logic [7:0] raw);
        if (raw[0]) mask_mode = {raw[7:4], 3'b000, 1'b1};
        else        mask_mode = {raw[7:6], 2'b00, raw[3:1], 1'b0};
    endfunction

endpackage

// File: rtl/portcmd_track.sv
module portcmd_track
    import portcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             opc_wr,
    input  logic             arg_wr,
    input  logic [7:0]       wdata,
    output logic [7:0]       cur_cmd,
    output logic [IDX_W-1:0] arg_idx,
    output logic             arg_take
);
    logic [IDX_W-1:0] need;

    always_comb begin
        need     = operand_count(cur_cmd);
        arg_take = arg_wr && (arg_idx < need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cmd <= OP_CLEAR;
            arg_idx <= '0;
        end else if (opc_wr) begin
            cur_cmd <= wdata;
            arg_idx <= '0;
        end else if (arg_take) begin
            arg_idx <= arg_idx + 1'b1;
        end
    end
endmodule

// File: rtl/portcmd_params.sv
module portcmd_params
    import portcmd_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opc_wr,
    input  logic             arg_take,
    input  logic [7:0]       cur_cmd,
    input  logic [IDX_W-1:0] arg_idx,
    input  logic [7:0]       wdata,
    output logic [LVL_W-1:0] flow_off_lvl,
    output logic [LVL_W-1:0] flow_on_lvl,
    output logic [LVL_W-1:0] rx_trig_lvl,
    output logic [LVL_W-1:0] tx_trig_lvl,
    output logic [7:0]       dma_tmo,
    output logic [7:0]       rxchr_tmo,
    output logic [7:0]       floff_tmo,
    output logic [15:0]      err_mask,
    output logic [7:0]       xon_chr,
    output logic [7:0]       xoff_chr,
    output logic [7:0]       esc_chr,
    output logic [7:0]       xor_chr,
    output logic [7:0]       cmp_mask,
    output logic [7:0]       mode_byte,
    output logic             flush_rx,
    output logic             flush_tx
);
    localparam int HI_W = LVL_W - 8;

    logic wipe;
    assign wipe = rst || (opc_wr && wdata == OP_CLEAR);

    always_ff @(posedge clk) begin
        if (wipe) begin
            flow_off_lvl <= '0;
            flow_on_lvl  <= '0;
            rx_trig_lvl  <= '0;
            tx_trig_lvl  <= '0;
            dma_tmo      <= '0;
            rxchr_tmo    <= '0;
            floff_tmo    <= '0;
            err_mask     <= '0;
            xon_chr      <= '0;
            xoff_chr     <= '0;
            esc_chr      <= '0;
            xor_chr      <= '0;
            cmp_mask     <= '0;
            mode_byte    <= '0;
        end else if (arg_take) begin
            case (cur_cmd)
                OP_DMA_TMO: dma_tmo   <= wdata;
                OP_RX_TMO:  rxchr_tmo <= wdata;
                OP_FL_TMO:  floff_tmo <= wdata;
                OP_MODE:    mode_byte <= mask_mode(wdata);
                OP_ERR_MASK: begin
                    if (arg_idx == 3'd0) err_mask[7:0]  <= wdata;
                    else                 err_mask[15:8] <= wdata;
                end
                OP_CHARS: begin
                    case (arg_idx)
                        3'd0:    xon_chr  <= wdata;
                        3'd1:    xoff_chr <= wdata;
                        3'd2:    esc_chr  <= wdata;
                        3'd3:    xor_chr  <= wdata;
                        default: cmp_mask <= wdata;
                    endcase
                end
                OP_FLOW_LVL: begin
                    case (arg_idx)
                        3'd0:    flow_off_lvl[LVL_W-1:8] <= wdata[HI_W-1:0];
                        3'd1:    flow_off_lvl[7:0]       <= wdata;
                        3'd2:    flow_on_lvl[LVL_W-1:8]  <= wdata[HI_W-1:0];
                        default: flow_on_lvl[7:0]        <= wdata;
                    endcase
                end
                OP_TRIG_LVL: begin
                    case (arg_idx)
                        3'd0:    rx_trig_lvl[LVL_W-1:8] <= wdata[HI_W-1:0];
                        3'd1:    rx_trig_lvl[7:0]       <= wdata;
                        3'd2:    tx_trig_lvl[LVL_W-1:8] <= wdata[HI_W-1:0];
                        default: tx_trig_lvl[7:0]       <= wdata;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_rx <= 1'b0;
            flush_tx <= 1'b0;
        end else begin
            flush_rx <= opc_wr && (wdata == OP_CLEAR || wdata == OP_FLUSH_RX);
            flush_tx <= opc_wr && (wdata == OP_CLEAR || wdata == OP_FLUSH_TX);
        end
    end
endmodule

// File: rtl/portcmd_result.sv
module portcmd_result
    import portcmd_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opc_wr,
    input  logic             res_close,
    input  logic [7:0]       wdata,
    input  logic [LVL_W-1:0] rx_count,
    input  logic [LVL_W-1:0] tx_space,
    input  logic [RES_W-1:0] err_count,
    input  logic [7:0]       mode_byte,
    output res_t             res_q
);
    localparam int PAD_W = RES_W - LVL_W;

    res_t snap;

    always_comb begin
        case (wdata)
            OP_RX_AVAIL: snap = res_t'({{PAD_W{1'b0}}, rx_count});
            OP_TX_AVAIL: snap = res_t'({{PAD_W{1'b0}}, tx_space});
            OP_ERR_CNT:  snap = res_t'(err_count);
            OP_GET_MODE: snap = '{hi: 8'h00, lo: mode_byte};
            default:     snap = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            res_q <= '0;
        else if (opc_wr)    res_q <= snap;
        else if (res_close) res_q <= '0;
    end
endmodule

// File: rtl/portcmd_seq.sv
module portcmd_seq
    import portcmd_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [LVL_W-1:0] rx_count,
    input  logic [LVL_W-1:0] tx_space,
    input  logic [15:0]      err_count,
    output logic [LVL_W-1:0] flow_off_lvl,
    output logic [LVL_W-1:0] flow_on_lvl,
    output logic [LVL_W-1:0] rx_trig_lvl,
    output logic [LVL_W-1:0] tx_trig_lvl,
    output logic [7:0]       dma_tmo,
    output logic [7:0]       rxchr_tmo,
    output logic [7:0]       floff_tmo,
    output logic [15:0]      err_mask,
    output logic [7:0]       xon_chr,
    output logic [7:0]       xoff_chr,
    output logic [7:0]       esc_chr,
    output logic [7:0]       xor_chr,
    output logic [7:0]       cmp_mask,
    output logic [7:0]       mode_byte,
    output logic             flush_rx,
    output logic             flush_tx
);
    logic             opc_wr, arg_wr, res_close, arg_take;
    logic [7:0]       cur_cmd;
    logic [IDX_W-1:0] arg_idx;
    res_t             res_q;
    logic [7:0]       stat_hi, stat_lo;

    assign opc_wr    = wr_en && addr == OFF_OPC;
    assign arg_wr    = wr_en && addr == OFF_ARG;
    assign res_close = rd_en && addr == OFF_ARG;
    assign stat_hi   = res_q.hi;
    assign stat_lo   = res_q.lo;

    portcmd_track u_trk (
        .clk(clk), .rst(rst), .opc_wr(opc_wr), .arg_wr(arg_wr),
        .wdata(wdata), .cur_cmd(cur_cmd), .arg_idx(arg_idx),
        .arg_take(arg_take)
    );

    portcmd_params #(.LVL_W(LVL_W)) u_prm (
        .clk(clk), .rst(rst), .opc_wr(opc_wr), .arg_take(arg_take),
        .cur_cmd(cur_cmd), .arg_idx(arg_idx), .wdata(wdata),
        .flow_off_lvl(flow_off_lvl), .flow_on_lvl(flow_on_lvl),
        .rx_trig_lvl(rx_trig_lvl), .tx_trig_lvl(tx_trig_lvl),
        .dma_tmo(dma_tmo), .rxchr_tmo(rxchr_tmo), .floff_tmo(floff_tmo),
        .err_mask(err_mask), .xon_chr(xon_chr), .xoff_chr(xoff_chr),
        .esc_chr(esc_chr), .xor_chr(xor_chr), .cmp_mask(cmp_mask),
        .mode_byte(mode_byte), .flush_rx(flush_rx), .flush_tx(flush_tx)
    );

    portcmd_result #(.LVL_W(LVL_W)) u_res (
        .clk(clk), .rst(rst), .opc_wr(opc_wr), .res_close(res_close),
        .wdata(wdata), .rx_count(rx_count), .tx_space(tx_space),
        .err_count(err_count), .mode_byte(mode_byte), .res_q(res_q)
    );

    always_comb begin
        rdata = 8'h00;
        if (rd_en) begin
            case (addr)
                OFF_OPC: rdata = stat_hi;
                OFF_ARG: rdata = stat_lo;
                default: rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/portcmd_chk.sv
module portcmd_chk
    import portcmd_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       wdata,
    input logic [7:0]       cur_cmd,
    input logic [IDX_W-1:0] arg_idx,
    input logic [7:0]       stat_hi,
    input logic [7:0]       stat_lo,
    input logic [LVL_W-1:0] flow_off_lvl,
    input logic [LVL_W-1:0] flow_on_lvl,
    input logic [LVL_W-1:0] rx_trig_lvl,
    input logic [LVL_W-1:0] tx_trig_lvl,
    input logic [15:0]      err_mask,
    input logic [7:0]       xon_chr,
    input logic [7:0]       cmp_mask,
    input logic [7:0]       mode_byte,
    input logic             flush_rx,
    input logic             flush_tx
);
    logic op_w, arg_w, lo_rd;
    assign op_w  = wr_en && addr == 3'd4;
    assign arg_w = wr_en && addr == 3'd5;
    assign lo_rd = rd_en && addr == 3'd5;

    // R4: a new opcode always restarts operand counting
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        op_w |=> arg_idx == '0);

    // R3: surplus or unexpected operands change nothing
    a_r3_surplus_ignored: assert property (@(posedge clk) disable iff (rst)
        (arg_w && arg_idx >= operand_count(cur_cmd)) |=>
        ($stable(flow_off_lvl) && $stable(flow_on_lvl) && $stable(rx_trig_lvl)
         && $stable(tx_trig_lvl) && $stable(err_mask) && $stable(xon_chr)
         && $stable(cmp_mask) && $stable(mode_byte)));

    // R11: clear opcode pulses both flush lines
    a_r11_clear_flush: assert property (@(posedge clk) disable iff (rst)
        (op_w && wdata == 8'h00) |=> (flush_rx && flush_tx));

    // R11: no flush pulse without an opcode write
    a_r11_no_stray_flush: assert property (@(posedge clk) disable iff (rst)
        !op_w |=> (!flush_rx && !flush_tx));

    // R9: result pair closes after a low-byte read
    a_r9_close: assert property (@(posedge clk) disable iff (rst)
        (lo_rd && !op_w) |=> (stat_hi == 8'h00 && stat_lo == 8'h00));

    // R9: result pair holds when neither an opcode nor a low-byte read occurs
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!lo_rd && !op_w) |=> ($stable(stat_hi) && $stable(stat_lo)));

    // R7: stored mode never keeps the bits its mode ignores
    a_r7_mode_clean: assert property (@(posedge clk) disable iff (rst)
        mode_byte[0] ? (mode_byte[3:1] == 3'b000) : (mode_byte[5:4] == 2'b00));
endmodule

bind portcmd_seq portcmd_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/sim_portcmd_seq.sv
`timescale 1ns/1ps
module sim_portcmd_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [9:0]  rx_count = 10'h2A5, tx_space = 10'h13C;
    logic [15:0] err_count = 16'hBEEF;
    logic [9:0]  flow_off_lvl, flow_on_lvl, rx_trig_lvl, tx_trig_lvl;
    logic [7:0]  dma_tmo, rxchr_tmo, floff_tmo;
    logic [15:0] err_mask;
    logic [7:0]  xon_chr, xoff_chr, esc_chr, xor_chr, cmp_mask, mode_byte;
    logic        flush_rx, flush_tx;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    portcmd_seq u0 (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 chk(tag, {8'h00, rdata}, {8'h00, exp});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // {kind(1=read), addr[2:0], data[7:0], expected[7:0]}
    localparam logic [19:0] VEC [0:23] = '{
        {1'b0, 3'd4, 8'h14, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h02},
        {1'b1, 3'd5, 8'h00, 8'hA5}, {1'b1, 3'd4, 8'h00, 8'h00},
        {1'b0, 3'd4, 8'h15, 8'h00}, {1'b1, 3'd5, 8'h00, 8'h3C},
        {1'b1, 3'd4, 8'h00, 8'h00}, {1'b0, 3'd4, 8'h22, 8'h00},
        {1'b1, 3'd4, 8'h00, 8'hBE}, {1'b1, 3'd4, 8'h00, 8'hBE},
        {1'b1, 3'd5, 8'h00, 8'hEF}, {1'b1, 3'd5, 8'h00, 8'h00},
        {1'b0, 3'd4, 8'h10, 8'h00}, {1'b0, 3'd5, 8'h03, 8'h00},
        {1'b0, 3'd4, 8'h1E, 8'h00}, {1'b1, 3'd4, 8'h00, 8'h00},
        {1'b1, 3'd5, 8'h00, 8'h01}, {1'b0, 3'd4, 8'h10, 8'h00},
        {1'b0, 3'd5, 8'h3A, 8'h00}, {1'b0, 3'd4, 8'h1E, 8'h00},
        {1'b1, 3'd5, 8'h00, 8'h0A}, {1'b1, 3'd6, 8'h00, 8'h00},
        {1'b0, 3'd4, 8'h22, 8'h00}, {1'b0, 3'd4, 8'h55, 8'h00}
    };

    initial begin
        #200000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 flow_off", {6'd0, flow_off_lvl}, 16'h0);
        chk("R12 mode", {8'd0, mode_byte}, 16'h0);
        chk("R12 flush", {14'd0, flush_rx, flush_tx}, 16'h0);
        rd(3'd4, 8'h00, "R12 stat hi");
        rst = 1'b0;
        @(negedge clk);

        // R8 R9 R10 R7 R1 table walk
        for (int i = 0; i < 24; i++) begin
            if (VEC[i][19]) rd(VEC[i][18:16], VEC[i][7:0], $sformatf("R8/R9/R10/R7/R1 vec %0d", i));
            else            wr(VEC[i][18:16], VEC[i][15:8]);
        end
        rd(3'd4, 8'h00, "R9 unknown opcode loads 00");

        // R2 flow and trigger levels
        wr(4, 8'h0A); wr(5, 8'h01); wr(5, 8'hF4); wr(5, 8'h00); wr(5, 8'hC8);
        chk("R2 flow off", {6'd0, flow_off_lvl}, 16'h1F4);
        chk("R2 flow on", {6'd0, flow_on_lvl}, 16'h0C8);
        wr(4, 8'h0B); wr(5, 8'h02); wr(5, 8'h00); wr(5, 8'h00); wr(5, 8'h40);
        chk("R2 rx trig", {6'd0, rx_trig_lvl}, 16'h200);
        chk("R2 tx trig", {6'd0, tx_trig_lvl}, 16'h040);
        // R3 surplus operand
        wr(5, 8'h77);
        chk("R3 surplus tx trig", {6'd0, tx_trig_lvl}, 16'h040);
        chk("R3 surplus rx trig", {6'd0, rx_trig_lvl}, 16'h200);
        // R3 unknown opcode operand
        wr(4, 8'h55); wr(5, 8'h99);
        chk("R3 unknown mode", {8'd0, mode_byte}, 16'h0A);
        chk("R3 unknown flow", {6'd0, flow_on_lvl}, 16'h0C8);
        // R1 write at other offset
        wr(4, 8'h05); wr(3'd6, 8'h42);
        chk("R1 other offset", {8'd0, dma_tmo}, 16'h0);

        // R4 abort
        wr(4, 8'h0A); wr(5, 8'h03); wr(4, 8'h0C); wr(5, 8'h20);
        chk("R4 partial", {6'd0, flow_off_lvl}, 16'h3F4);
        chk("R4 untouched", {6'd0, flow_on_lvl}, 16'h0C8);
        chk("R4 new command", {8'd0, rxchr_tmo}, 16'h20);

        // R5
        wr(4, 8'h09); wr(5, 8'h11); wr(5, 8'h13); wr(5, 8'h10); wr(5, 8'h21); wr(5, 8'h7F);
        chk("R5 xon", {8'd0, xon_chr}, 16'h11);
        chk("R5 xoff", {8'd0, xoff_chr}, 16'h13);
        chk("R5 esc", {8'd0, esc_chr}, 16'h10);
        chk("R5 xor", {8'd0, xor_chr}, 16'h21);
        chk("R5 mask", {8'd0, cmp_mask}, 16'h7F);
        wr(4, 8'h07); wr(5, 8'hA5); wr(5, 8'h0F);
        chk("R5 err mask", err_mask, 16'h0FA5);

        // R6
        wr(4, 8'h05); wr(5, 8'h64);
        chk("R6 dma tmo", {8'd0, dma_tmo}, 16'h64);
        wr(4, 8'h0D); wr(5, 8'h1E);
        chk("R6 flow off tmo", {8'd0, floff_tmo}, 16'h1E);

        // R11 flush pulses
        wr(4, 8'h1B);
        chk("R11 flush rx only", {14'd0, flush_rx, flush_tx}, 16'h2);
        @(negedge clk);
        chk("R11 pulse ends", {14'd0, flush_rx, flush_tx}, 16'h0);
        wr(4, 8'h1C);
        chk("R11 flush tx only", {14'd0, flush_rx, flush_tx}, 16'h1);
        wr(4, 8'h00);
        chk("R11 clear flush", {14'd0, flush_rx, flush_tx}, 16'h3);
        chk("R11 clear levels", {6'd0, flow_off_lvl}, 16'h0);
        chk("R11 clear chars", {8'd0, xon_chr}, 16'h0);
        chk("R11 clear mask", err_mask, 16'h0);
        chk("R11 clear tmo", {8'd0, dma_tmo}, 16'h0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule